// File: doc/BRIEF.md
# Serially Configured Output Selector

This block is a two-wire serial target that holds a six-bit configuration word and drives six outputs from it. Five of the outputs pass through a two-way selector. Each one shows either its configuration bit or the matching external input. The sixth output comes from a hold stage that follows the top configuration bit while the select line is low. It keeps that value once select goes high.

A bus controller writes or reads the configuration word in a single transfer of one data byte. The transfer is addressed to a seven-bit target address, and two strap pins fix the low two bits of that address. A write-protect pin blocks stores to the word. An active-low override pin forces every output to zero, but only while select is low.

The serial lines are brought onto the system clock through synchronizer chains. The target pulls SDA low to acknowledge and to send read data. The non-volatile word is modelled as a register that clears on reset.

Top module: `cfgmux_i2c`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 10011 followed by strapAddr[1] and strapAddr[0]. It never pulls SDA low for any other address, and it ignores the rest of that transfer.
- R2: In a write transfer (address bit 0 equal to 0) the data byte is stored as follows: bit 5 is the held-output bit, and bits 4..0 are selector bits E..A, with A in bit 0. Bits 7 and 6 of the byte are discarded.
- R3: In a read transfer (address bit 0 equal to 1) the target shifts out, MSB first, a byte with bits 7:6 at zero and bits 5:0 equal to the stored word.
- R4: While writeProtect is 1, a written data byte is still acknowledged, but the stored word does not change.
- R5: After reset the stored word is zero, SDA is released, and all six outputs are zero.
- R6: With muxSel at 0 and overrideN at 1, muxOut equals stored bits 4..0. With muxSel at 1, muxOut equals extIn.
- R7: With muxSel at 0 and overrideN at 1, fixedOut follows stored bit 5. While muxSel is 1, fixedOut keeps the value stored bit 5 had when muxSel rose, even when the word is rewritten or overrideN changes.
- R8: With overrideN at 0 and muxSel at 0, muxOut and fixedOut are all zero.
- R9: With overrideN at 0 and muxSel at 1, the override has no effect: muxOut follows extIn and fixedOut keeps its held value.
- R10: A start or stop condition that arrives before all eight data bits of a write ends the transfer, and the stored word does not change.
- R11: Each transfer carries one data byte only. A second written byte is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaPullLow | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| strapAddr | input | 2 | Low two bits of the target address |
| writeProtect | input | 1 | 1 blocks stores to the configuration word |
| muxSel | input | 1 | 0 shows stored bits, 1 shows extIn; also controls the hold stage |
| overrideN | input | 1 | Active-low force-to-zero, effective only while muxSel is 0 |
| extIn | input | MUX_W | External inputs to the selector |
| muxOut | output | MUX_W | Selector outputs |
| fixedOut | output | 1 | Held output from stored bit 5 |

## Verification
The bench builds the block with its default parameters: five selector bits, a two-stage synchronizer and the 10011 address prefix. A quarter bit period of eight system clocks leaves room for the synchronizer and edge detection before each sampling point. Because the strap pins are ordinary inputs, the bench changes them between transfers to cover both a matching and a mismatching low address pair. It drives muxSel and overrideN in every combination, and it rewrites the word while the held output is frozen.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WEND,
    ST_WACK,
    ST_RDATA,
    ST_SKIP
  } busState_t;

  // strobes from serial control to the configuration datapath
  typedef struct packed {
    logic wrEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/cfgmux_ctrl.sv
module cfgmux_ctrl
  import cfgmux_pkg::*;
#(
  parameter int           SYNC_STAGES = 2,
  parameter logic [4:0]   ADDR_HI     = 5'b10011,
  parameter int           REG_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [1:0]       strapAddr,
  input  logic [REG_W-1:0] regValue,
  output ctrlStrobe_t      strobe,
  output logic [REG_W-1:0] wrData,
  output logic             sdaPullLow
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftQ, txQ, readByte;
  logic rwQ, wrPulse;

  // two-wire lines onto the system clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
    end
  end

  assign sclS     = sclChain[SYNC_STAGES-1];
  assign sdaS     = sdaChain[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign readByte = {{(BYTE_W-REG_W){1'b0}}, regValue};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftQ     <= '0;
      txQ        <= '0;
      rwQ        <= 1'b0;
      wrPulse    <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      wrPulse <= 1'b0;
      if (startDet) begin
        state      <= ST_ADDR;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopDet) begin
        state      <= ST_IDLE;
        sdaPullLow <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDATA: begin
            if (sclRise) begin
              shiftQ <= {shiftQ[BYTE_W-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == CNT_W'(BYTE_W - 1))
                state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WEND;
            end
          end
          ST_ADDR_END: begin
            if (sclFall) begin
              if (shiftQ[BYTE_W-1:1] == {ADDR_HI, strapAddr}) begin
                sdaPullLow <= 1'b1;
                rwQ        <= shiftQ[0];
                state      <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rwQ) begin
                txQ        <= readByte;
                sdaPullLow <= ~readByte[BYTE_W-1];
                state      <= ST_RDATA;
              end else begin
                sdaPullLow <= 1'b0;
                state      <= ST_WDATA;
              end
            end
          end
          ST_WEND: begin
            if (sclFall) begin
              wrPulse    <= 1'b1;
              sdaPullLow <= 1'b1;
              state      <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (sclFall) begin
              sdaPullLow <= 1'b0;
              state      <= ST_SKIP;
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == CNT_W'(BYTE_W)) begin
                sdaPullLow <= 1'b0;
                state      <= ST_SKIP;
              end else begin
                txQ        <= {txQ[BYTE_W-2:0], txQ[BYTE_W-1]};
                sdaPullLow <= ~txQ[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign strobe.wrEn = wrPulse;
  assign wrData      = shiftQ[REG_W-1:0];

  // R1: SDA is only ever pulled low while the clock line is low
  a_r1_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaPullLow) |-> !sclS);

  // R1: an idle target leaves SDA released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sdaPullLow);

  // R11: one store pulse per transfer, never back to back
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> !strobe.wrEn);

  // R10: a start condition never leads into a store
  a_r10_start_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    startDet |=> !strobe.wrEn);

endmodule

// File: rtl/cfgmux_dp.sv
module cfgmux_dp
  import cfgmux_pkg::*;
#(
  parameter int MUX_W = 5,
  parameter int REG_W = MUX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             writeProtect,
  input  logic             muxSel,
  input  logic             overrideN,
  input  logic [MUX_W-1:0] extIn,
  output logic [REG_W-1:0] regValue,
  output logic [MUX_W-1:0] muxOut,
  output logic             fixedOut
);

  logic [REG_W-1:0] regQ, regNext;
  logic heldQ, forceZero;

  always_comb begin
    regNext = regQ;
    if (strobe.wrEn && !writeProtect) regNext = wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regQ  <= '0;
      heldQ <= 1'b0;
    end else begin
      regQ <= regNext;
      if (!muxSel) heldQ <= regNext[REG_W-1];
    end
  end

  assign regValue  = regQ;
  assign forceZero = !overrideN && !muxSel;

  for (genvar i = 0; i < MUX_W; i++) begin : g_sel
    assign muxOut[i] = forceZero ? 1'b0 : (muxSel ? extIn[i] : regQ[i]);
  end

  assign fixedOut = muxSel ? heldQ : (forceZero ? 1'b0 : regQ[REG_W-1]);

  // R4: a protected store leaves the word untouched
  a_r4_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && writeProtect) |=> $stable(regQ));

  // R7: the held output is frozen while select stays high
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (muxSel && $past(muxSel)) |-> (fixedOut == $past(fixedOut)));

  // R9: with select high the selector follows the external inputs
  a_r9_select_ext: assert property (@(posedge clk) disable iff (!rst_n)
    muxSel |-> (muxOut == extIn));

  // R8: override with select low clears every output
  a_r8_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrideN && !muxSel) |-> (muxOut == '0 && !fixedOut));

endmodule

// File: rtl/cfgmux_i2c.sv
module cfgmux_i2c
  import cfgmux_pkg::*;
#(
  parameter int         MUX_W       = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  input  logic [1:0]       strapAddr,
  input  logic             writeProtect,
  input  logic             muxSel,
  input  logic             overrideN,
  input  logic [MUX_W-1:0] extIn,
  output logic [MUX_W-1:0] muxOut,
  output logic             fixedOut
);

  localparam int REG_W = MUX_W + 1;

  ctrlStrobe_t      strobe;
  logic [REG_W-1:0] wrData, regValue;

  cfgmux_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_HI    (ADDR_HI),
    .REG_W      (REG_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapAddr (strapAddr),
    .regValue  (regValue),
    .strobe    (strobe),
    .wrData    (wrData),
    .sdaPullLow(sdaPullLow)
  );

  cfgmux_dp #(
    .MUX_W(MUX_W),
    .REG_W(REG_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .wrData      (wrData),
    .writeProtect(writeProtect),
    .muxSel      (muxSel),
    .overrideN   (overrideN),
    .extIn       (extIn),
    .regValue    (regValue),
    .muxOut      (muxOut),
    .fixedOut    (fixedOut)
  );

endmodule

// File: tb/cfgmux_i2c_bench.sv
module cfgmux_i2c_bench;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [1:0] strapAddr = 2'b01;
  logic writeProtect = 1'b0, muxSel = 1'b0, overrideN = 1'b1;
  logic [4:0] extIn = 5'b0;
  logic sdaPullLow, fixedOut;
  logic [4:0] muxOut;
  logic busSda;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign busSda = mSda & ~sdaPullLow;

  cfgmux_i2c u_cfgmux_i2c (
    .clk(clk), .rst_n(rst_n), .sclIn(mScl), .sdaIn(busSda),
    .sdaPullLow(sdaPullLow), .strapAddr(strapAddr), .writeProtect(writeProtect),
    .muxSel(muxSel), .overrideN(overrideN), .extIn(extIn),
    .muxOut(muxOut), .fixedOut(fixedOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bStart();
    mSda = 1'b1; qwait(); mScl = 1'b1; qwait();
    mSda = 1'b0; qwait(); mScl = 1'b0; qwait();
  endtask

  task automatic bStop();
    mSda = 1'b0; qwait(); mScl = 1'b1; qwait(); mSda = 1'b1; qwait();
  endtask

  task automatic bBit(input logic b, output logic r);
    mSda = b; qwait(); mScl = 1'b1; qwait();
    r = busSda; qwait(); mScl = 1'b0; qwait();
  endtask

  task automatic bByte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bBit(d[i], r);
    bBit(1'b1, r);
    ack = !r;
  endtask

  task automatic bRecv(output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bBit(1'b1, r); d[i] = r; end
    bBit(1'b1, r);
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] a, input logic rd);
    return {5'b10011, a, rd};
  endfunction

  task automatic writeCfg(input logic [1:0] a, input logic [7:0] d,
                          output logic ackA, output logic ackD);
    bStart();
    bByte(addrByte(a, 1'b0), ackA);
    bByte(d, ackD);
    bStop();
  endtask

  task automatic readCfg(output logic ackA, output logic [7:0] d);
    bStart();
    bByte(addrByte(strapAddr, 1'b1), ackA);
    bRecv(d);
    bStop();
  endtask

  function automatic logic [7:0] outs();
    return {2'b00, fixedOut, muxOut};
  endfunction

  task automatic tReset();
    logic a; logic [7:0] d;
    chk("R5 outputs after reset", outs(), 8'h00);
    chk("R5 sda released", {7'b0, sdaPullLow}, 8'h00);
    readCfg(a, d);
    chk("R5 read after reset", d, 8'h00);
  endtask

  task automatic tWrite();
    logic a, b;
    writeCfg(strapAddr, 8'h35, a, b);
    chk("R1 address ack", {7'b0, a}, 8'h01);
    chk("R2 data ack", {7'b0, b}, 8'h01);
    chk("R6 mux shows stored", {3'b0, muxOut}, 8'h15);
    chk("R7 held bit transparent", {7'b0, fixedOut}, 8'h01);
  endtask

  task automatic tReadBack();
    logic a; logic [7:0] d;
    readCfg(a, d);
    chk("R3 read ack", {7'b0, a}, 8'h01);
    chk("R3 read value", d, 8'h35);
  endtask

  task automatic tUpperBits();
    logic a, b; logic [7:0] d;
    writeCfg(strapAddr, 8'hE9, a, b);
    readCfg(a, d);
    chk("R2 upper bits dropped", d, 8'h29);
    chk("R2 outputs", outs(), 8'h29);
  endtask

  task automatic tProtect();
    logic a, b; logic [7:0] d;
    writeProtect = 1'b1;
    writeCfg(strapAddr, 8'h12, a, b);
    chk("R4 protected byte acked", {7'b0, b}, 8'h01);
    chk("R4 outputs unchanged", outs(), 8'h29);
    readCfg(a, d);
    chk("R4 word unchanged", d, 8'h29);
    writeProtect = 1'b0;
  endtask

  task automatic tAddrMiss();
    logic a, b;
    logic sawPull = 1'b0;
    fork
      writeCfg(2'b10, 8'h07, a, b);
      begin
        repeat (22 * 4 * Q + 6 * Q) begin
          @(negedge clk);
          if (sdaPullLow) sawPull = 1'b1;
        end
      end
    join
    chk("R1 mismatch no addr ack", {7'b0, a}, 8'h00);
    chk("R1 mismatch no data ack", {7'b0, b}, 8'h00);
    chk("R1 mismatch never drives", {7'b0, sawPull}, 8'h00);
    chk("R1 mismatch no store", outs(), 8'h29);
  endtask

  task automatic tStrap();
    logic a, b;
    strapAddr = 2'b10;
    writeCfg(2'b10, 8'h0C, a, b);
    chk("R1 new strap ack", {7'b0, a}, 8'h01);
    chk("R1 new strap store", outs(), 8'h0C);
  endtask

  task automatic tSelect();
    extIn = 5'h1A;
    muxSel = 1'b1; qwait();
    chk("R6 select external", {3'b0, muxOut}, 8'h1A);
    muxSel = 1'b0; qwait();
    chk("R6 select stored", {3'b0, muxOut}, 8'h0C);
  endtask

  task automatic tLatch();
    logic a, b;
    writeCfg(strapAddr, 8'h3F, a, b);
    chk("R7 transparent high", {7'b0, fixedOut}, 8'h01);
    muxSel = 1'b1; qwait();
    writeCfg(strapAddr, 8'h00, a, b);
    chk("R7 held across write", {7'b0, fixedOut}, 8'h01);
    chk("R6 external while held", {3'b0, muxOut}, 8'h1A);
    muxSel = 1'b0; qwait();
    chk("R7 transparent after release", outs(), 8'h00);
  endtask

  task automatic tOverride();
    logic a, b;
    writeCfg(strapAddr, 8'h3F, a, b);
    overrideN = 1'b0; qwait();
    chk("R8 forced zero", outs(), 8'h00);
    muxSel = 1'b1; qwait();
    chk("R9 override inert mux", {3'b0, muxOut}, 8'h1A);
    chk("R9 override inert held", {7'b0, fixedOut}, 8'h01);
    extIn = 5'h05; qwait();
    chk("R9 follows ext", {3'b0, muxOut}, 8'h05);
    muxSel = 1'b0; qwait();
    chk("R8 forced again", outs(), 8'h00);
    overrideN = 1'b1; qwait();
    chk("R8 released", outs(), 8'h3F);
  endtask

  task automatic tAbort();
    logic a, r; logic [7:0] d;
    bStart();
    bByte(addrByte(strapAddr, 1'b0), a);
    for (int i = 0; i < 4; i++) bBit(1'b0, r);
    bStop();
    chk("R10 stop mid byte", outs(), 8'h3F);
    bStart();
    bByte(addrByte(strapAddr, 1'b0), a);
    for (int i = 0; i < 5; i++) bBit(1'b0, r);
    bStart();
    bByte(addrByte(strapAddr, 1'b1), a);
    bRecv(d);
    bStop();
    chk("R10 restart mid byte", d, 8'h3F);
  endtask

  task automatic tOneByte();
    logic a, b, c;
    bStart();
    bByte(addrByte(strapAddr, 1'b0), a);
    bByte(8'h05, b);
    bByte(8'h3A, c);
    bStop();
    chk("R11 first byte ack", {7'b0, b}, 8'h01);
    chk("R11 second byte nack", {7'b0, c}, 8'h00);
    chk("R11 only first stored", outs(), 8'h05);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tWrite();
    tReadBack();
    tUpperBits();
    tProtect();
    tAddrMiss();
    tStrap();
    tSelect();
    tLatch();
    tOverride();
    tAbort();
    tOneByte();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule